// File: doc/BRIEF.md
# CAN Transmit Request Scheduler

This block keeps the request state for a bank of up to 32 transmit message slots and decides which pending slot is handed next to a CAN protocol engine. The host raises add-request bits, one per slot, as write-one-to-set pulses. A static partition tells the block how many of the lowest-numbered slots are dedicated, and whether the remaining slots behave as a FIFO or as an identifier-ordered queue. Each slot also presents its message identifier.

The engine sees a slot index with a valid flag. Once it starts working on that slot, the offer is frozen. When the frame has gone out, the engine returns a one-cycle success pulse. The block then drops the slot's pending bit and sets its transmission-occurred bit. A masked interrupt pulse marks each completion. Dedicated slots keep their contents, so a frame that is sent often can be resent simply by raising its add bit again.

Top module: `can_tx_sched`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `pending_o`, `occurred_o`, `sel_valid_o` and `irq_o` are all zero.
- R2: A bit set in `add_req_i` for a slot that is not pending sets that slot's bit in `pending_o` from the next cycle on.
- R3: A cycle with `tx_done_i` high while `sel_valid_o` is high clears the offered slot's `pending_o` bit and sets its `occurred_o` bit in the next cycle.
- R4: An add request for a slot that is already pending changes nothing. An accepted add request clears that slot's `occurred_o` bit in the next cycle.
- R5: With `queue_mode_i` = 1, the candidate among the pending non-dedicated slots is the one with the lowest identifier. Equal identifiers go to the lower slot index.
- R6: With `queue_mode_i` = 0, the candidate among the pending non-dedicated slots is the one added earliest, whatever its identifier. Slots added in the same cycle count as added in ascending index order.
- R7: Slots with index below `ded_count_i` are dedicated. The offered slot is the lowest identifier among the pending dedicated slots and the R5/R6 candidate. An identifier tie goes to the lower slot index.
- R8: A dedicated slot that has already been sent is sent again after a new add request, with no other input change.
- R9: When a cycle has `eng_busy_i` = 1, `tx_done_i` = 0 and `sel_valid_o` = 1, the next cycle offers the same index with `sel_valid_o` still high. The choice is made again after a success pulse or after a cycle with `eng_busy_i` = 0.
- R10: `sel_valid_o` is 0 when no slot is pending. When `sel_valid_o` is 1, the offered slot is pending. With no hold in force, the offer follows the pending state one cycle after an add.
- R11: `irq_o` is high for one cycle, the cycle after a success pulse, exactly when `irq_mask_i` has the completed slot's bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| add_req_i | input | N_SLOTS | Write-one-to-set add request per slot |
| ded_count_i | input | $clog2(N_SLOTS+1) | Number of dedicated slots, starting at index 0 |
| queue_mode_i | input | 1 | 1: identifier-ordered queue, 0: FIFO for non-dedicated slots |
| slot_id_i | input | N_SLOTS*ID_W | Message identifier per slot, slot k at bits k*ID_W upward |
| irq_mask_i | input | N_SLOTS | Per-slot interrupt enable |
| eng_busy_i | input | 1 | Engine is working on the offered slot |
| tx_done_i | input | 1 | One-cycle successful transmission pulse |
| sel_idx_o | output | $clog2(N_SLOTS) | Index of the offered slot |
| sel_valid_o | output | 1 | An offered slot exists |
| pending_o | output | N_SLOTS | Pending request per slot |
| occurred_o | output | N_SLOTS | Transmission occurred per slot |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The hardest case to reach is a held offer that disagrees with the live arbitration. A better candidate has to arrive while the engine is busy, and the hold must then be released both by a success pulse and, separately, by the engine going idle without one. The stimulus places a high identifier in queue mode, raises busy, and only then adds a lower identifier. It compares the frozen index against the reference model each cycle, and repeats the sequence ending with busy falling and no completion. FIFO ordering against identifiers is reached by adding slots whose identifiers run opposite to their arrival order, including two slots added in the same cycle and a repeated add of a pending slot.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;
  localparam int unsigned MAX_SLOTS = 32;
  typedef enum logic {
    MODE_FIFO  = 1'b0,
    MODE_QUEUE = 1'b1
  } txs_mode_e;
endpackage

// File: rtl/txs_min_id_pick.sv
module txs_min_id_pick #(
  parameter int unsigned N_SLOTS = 32,
  parameter int unsigned ID_W    = 11,
  localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0]      cand_i,
  input  logic [N_SLOTS*ID_W-1:0] id_i,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [ID_W-1:0] best_id;

  // strict compare keeps the lower index on equal ids
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best_id = '0;
    for (int i = 0; i < int'(N_SLOTS); i++) begin
      if (cand_i[i] && (!valid_o || id_i[i*ID_W +: ID_W] < best_id)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        best_id = id_i[i*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/txs_fifo_age.sv
module txs_fifo_age #(
  parameter int unsigned N_SLOTS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] new_i,
  input  logic [N_SLOTS-1:0] live_i,
  output logic [N_SLOTS-1:0] head_o
);
  // older_q[i][j]: slot j was added before slot i
  logic [N_SLOTS-1:0] older_q [N_SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_SLOTS); i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(N_SLOTS); i++) begin
        for (int j = 0; j < int'(N_SLOTS); j++) begin
          if (new_i[i])      older_q[i][j] <= live_i[j] | (new_i[j] && (j < i));
          else if (new_i[j]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_head
    logic [N_SLOTS-1:0] self_n;
    assign self_n    = ~(N_SLOTS'(1) << g);
    assign head_o[g] = live_i[g] & ~|(older_q[g] & live_i & self_n);
  end
endmodule

// File: rtl/txs_req_state.sv
module txs_req_state #(
  parameter int unsigned N_SLOTS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] add_i,
  input  logic [N_SLOTS-1:0] done_i,
  output logic [N_SLOTS-1:0] new_o,
  output logic [N_SLOTS-1:0] pending_o,
  output logic [N_SLOTS-1:0] occurred_o
);
  assign new_o = add_i & ~pending_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o  <= '0;
      occurred_o <= '0;
    end else begin
      pending_o  <= (pending_o & ~done_i) | new_o;
      occurred_o <= (occurred_o | done_i) & ~new_o;
    end
  end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_txs_pkg::*;
#(
  parameter int unsigned N_SLOTS = MAX_SLOTS,
  parameter int unsigned ID_W    = 11,
  localparam int unsigned IDX_W  = $clog2(N_SLOTS),
  localparam int unsigned CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SLOTS-1:0]      add_req_i,
  input  logic [CNT_W-1:0]        ded_count_i,
  input  logic                    queue_mode_i,
  input  logic [N_SLOTS*ID_W-1:0] slot_id_i,
  input  logic [N_SLOTS-1:0]      irq_mask_i,
  input  logic                    eng_busy_i,
  input  logic                    tx_done_i,
  output logic [IDX_W-1:0]        sel_idx_o,
  output logic                    sel_valid_o,
  output logic [N_SLOTS-1:0]      pending_o,
  output logic [N_SLOTS-1:0]      occurred_o,
  output logic                    irq_o
);
  txs_mode_e          mode;
  logic [N_SLOTS-1:0] ded_mask, done_vec, new_vec, pool;
  logic [N_SLOTS-1:0] q_onehot, f_head, cand, final_set;
  logic               q_valid, live_valid, hold_q, irq_q;
  logic [IDX_W-1:0]   q_idx, live_idx, held_q;

  assign mode = txs_mode_e'(queue_mode_i);

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_ded
    assign ded_mask[g] = CNT_W'(g) < ded_count_i;
  end

  assign done_vec = (tx_done_i && sel_valid_o) ? (N_SLOTS'(1) << sel_idx_o) : '0;

  txs_req_state #(.N_SLOTS(N_SLOTS)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_i      (add_req_i),
    .done_i     (done_vec),
    .new_o      (new_vec),
    .pending_o  (pending_o),
    .occurred_o (occurred_o)
  );

  assign pool = pending_o & ~ded_mask;

  txs_min_id_pick #(.N_SLOTS(N_SLOTS), .ID_W(ID_W)) u_queue_pick (
    .cand_i  (pool),
    .id_i    (slot_id_i),
    .valid_o (q_valid),
    .idx_o   (q_idx)
  );
  assign q_onehot = q_valid ? (N_SLOTS'(1) << q_idx) : '0;

  txs_fifo_age #(.N_SLOTS(N_SLOTS)) u_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .new_i  (new_vec),
    .live_i (pool),
    .head_o (f_head)
  );

  assign cand      = (mode == MODE_QUEUE) ? q_onehot : f_head;
  assign final_set = (pending_o & ded_mask) | cand;

  txs_min_id_pick #(.N_SLOTS(N_SLOTS), .ID_W(ID_W)) u_final_pick (
    .cand_i  (final_set),
    .id_i    (slot_id_i),
    .valid_o (live_valid),
    .idx_o   (live_idx)
  );

  // freeze the offer while the engine owns it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      held_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= eng_busy_i & ~tx_done_i & sel_valid_o;
      held_q <= sel_idx_o;
      irq_q  <= |(done_vec & irq_mask_i);
    end
  end

  assign sel_valid_o = hold_q | live_valid;
  assign sel_idx_o   = hold_q ? held_q : live_idx;
  assign irq_o       = irq_q;
endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
  parameter int unsigned N_SLOTS = 32,
  localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SLOTS-1:0] add_req_i,
  input logic [N_SLOTS-1:0] irq_mask_i,
  input logic               eng_busy_i,
  input logic               tx_done_i,
  input logic [IDX_W-1:0]   sel_idx_o,
  input logic               sel_valid_o,
  input logic [N_SLOTS-1:0] pending_o,
  input logic [N_SLOTS-1:0] occurred_o,
  input logic               irq_o
);
  assert_add_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(add_req_i & ~pending_o)) |=>
      ((pending_o & $past(add_req_i & ~pending_o)) == $past(add_req_i & ~pending_o)));

  assert_done_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && sel_valid_o) |=>
      (!pending_o[$past(sel_idx_o)] && occurred_o[$past(sel_idx_o)]));

  assert_add_clears_occ_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(add_req_i & ~pending_o)) |=> ((occurred_o & $past(add_req_i & ~pending_o)) == '0));

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy_i && !tx_done_i && sel_valid_o) |=> (sel_valid_o && $stable(sel_idx_o)));

  assert_offer_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> pending_o[sel_idx_o]);

  assert_idle_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o == '0) |-> !sel_valid_o);

  assert_irq_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(occurred_o & ~$past(occurred_o) & $past(irq_mask_i))));
endmodule

bind can_tx_sched can_tx_sched_chk #(.N_SLOTS(N_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .add_req_i   (add_req_i),
  .irq_mask_i  (irq_mask_i),
  .eng_busy_i  (eng_busy_i),
  .tx_done_i   (tx_done_i),
  .sel_idx_o   (sel_idx_o),
  .sel_valid_o (sel_valid_o),
  .pending_o   (pending_o),
  .occurred_o  (occurred_o),
  .irq_o       (irq_o)
);

// File: tb/can_tx_sched_bench.sv
`timescale 1ns/1ps
module can_tx_sched_bench;
  localparam int N = 32;
  localparam int ID_W = 11;
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] add_req = '0;
  logic [CNT_W-1:0] ded_cnt = '0;
  logic qmode = 1'b0;
  logic [N*ID_W-1:0] slot_id;
  logic [N-1:0] irq_mask = '0;
  logic eng_busy = 1'b0;
  logic tx_done = 1'b0;
  logic [IDX_W-1:0] sel_idx;
  logic sel_valid;
  logic [N-1:0] pending, occurred;
  logic irq;
  logic [ID_W-1:0] ids [N];

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit finished = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) slot_id[i*ID_W +: ID_W] = ids[i];

  can_tx_sched #(.N_SLOTS(N), .ID_W(ID_W)) u_can_tx_sched (
    .clk_i(clk), .rst_ni(rst_n), .add_req_i(add_req), .ded_count_i(ded_cnt),
    .queue_mode_i(qmode), .slot_id_i(slot_id), .irq_mask_i(irq_mask),
    .eng_busy_i(eng_busy), .tx_done_i(tx_done), .sel_idx_o(sel_idx),
    .sel_valid_o(sel_valid), .pending_o(pending), .occurred_o(occurred), .irq_o(irq)
  );

  // behavioural reference
  bit m_pend [N];
  bit m_occ [N];
  int fq [$];
  bit m_hold;
  int m_held;
  bit m_irq;

  function automatic void exp_sel(output bit v, output int idx);
    int cand = -1;
    int best = -1;
    if (m_hold) begin v = 1; idx = m_held; return; end
    if (qmode) begin
      for (int i = 0; i < N; i++)
        if (m_pend[i] && i >= int'(ded_cnt) && (cand < 0 || ids[i] < ids[cand])) cand = i;
    end else begin
      foreach (fq[k]) if (cand < 0 && m_pend[fq[k]]) cand = fq[k];
    end
    for (int i = 0; i < N; i++)
      if (((m_pend[i] && i < int'(ded_cnt)) || i == cand) && (best < 0 || ids[i] < ids[best])) best = i;
    v = (best >= 0);
    idx = v ? best : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_occ[i] = 0; end
      fq.delete(); m_hold = 0; m_held = 0; m_irq = 0;
    end else begin
      bit v, done;
      int idx;
      bit snap [N];
      exp_sel(v, idx);
      done = tx_done && v;
      snap = m_pend;
      m_hold = eng_busy && !tx_done && v;
      m_held = idx;
      m_irq = done && irq_mask[idx];
      if (done) begin
        m_pend[idx] = 0; m_occ[idx] = 1;
        for (int k = fq.size() - 1; k >= 0; k--) if (fq[k] == idx) fq.delete(k);
      end
      for (int i = 0; i < N; i++)
        if (add_req[i] && !snap[i]) begin
          m_pend[i] = 1; m_occ[i] = 0;
          if (i >= int'(ded_cnt)) fq.push_back(i);
        end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit v;
      int idx;
      logic [N-1:0] ep, eo;
      for (int i = 0; i < N; i++) begin ep[i] = m_pend[i]; eo[i] = m_occ[i]; end
      exp_sel(v, idx);
      chk(pending == ep, "R2", "pending", pending, ep);
      chk(occurred == eo, "R3", "occurred", occurred, eo);
      chk(irq == m_irq, "R11", "irq", irq, m_irq);
      chk(sel_valid == v, cur_req, "sel_valid", sel_valid, v);
      if (v) chk(int'(sel_idx) == idx, cur_req, "sel_idx", sel_idx, idx);
      if (irq) irq_cnt++;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic add(logic [N-1:0] m);
    add_req = m; step(); add_req = '0;
  endtask

  task automatic send_one(output int idx);
    int guard = 0;
    while (!sel_valid && guard < 50) begin step(); guard++; end
    idx = sel_valid ? int'(sel_idx) : -1;
    eng_busy = 1; step(); step(); step();
    tx_done = 1; step();
    tx_done = 0; eng_busy = 0; step();
  endtask

  task automatic expect_order(string req, int exp [$]);
    foreach (exp[k]) begin
      int got;
      send_one(got);
      chk(got == exp[k], req, "send order", got, exp[k]);
    end
  endtask

  function automatic logic [N-1:0] bits(int l [$]);
    logic [N-1:0] r = '0;
    foreach (l[k]) r[l[k]] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) ids[i] = ID_W'(1000 + i);
    ids[5] = 100; ids[2] = 10; ids[9] = 1; ids[3] = 50; ids[20] = 5;
    repeat (3) step();
    chk(pending == '0 && occurred == '0 && !sel_valid && !irq, "R1", "reset outputs",
        {pending, occurred}, 0);
    rst_n = 1;
    step();
    chk(pending == '0 && !sel_valid && !irq, "R1", "after release", pending, 0);

    // FIFO, ids run against arrival
    cur_req = "R6";
    add(bits({5})); add(bits({2})); add(bits({9})); add(bits({3, 20}));
    add(bits({5}));
    chk(pending == bits({2, 3, 5, 9, 20}), "R4", "re-add of pending slot", pending,
        bits({2, 3, 5, 9, 20}));
    expect_order("R6", {5, 2, 9, 3, 20});
    cur_req = "R10";
    chk(!sel_valid, "R10", "empty bank offers nothing", sel_valid, 0);
    chk(occurred == bits({2, 3, 5, 9, 20}), "R3", "occurred set", occurred,
        bits({2, 3, 5, 9, 20}));

    // queue ordering with a tie
    qmode = 1; cur_req = "R5";
    ids[7] = 300; ids[8] = 200; ids[12] = 200; ids[30] = 7;
    add(bits({5, 7, 8, 12, 30}));
    chk(occurred[5] == 1'b0, "R4", "add clears occurred", occurred[5], 0);
    expect_order("R5", {30, 5, 8, 12, 7});

    // dedicated slots competing with the queue
    ded_cnt = 4; cur_req = "R7";
    ids[1] = 50; ids[10] = 40; ids[11] = 60; ids[2] = 60;
    add(bits({1, 2, 10, 11}));
    expect_order("R7", {10, 1, 2, 11});

    // dedicated resend
    cur_req = "R8";
    add(bits({1}));
    chk(pending[1] && !occurred[1], "R8", "dedicated re-armed", {pending[1], occurred[1]}, 2);
    expect_order("R8", {1});
    chk(occurred[1], "R8", "dedicated resent", occurred[1], 1);

    // hold across a better arrival, release by completion
    ded_cnt = 0; cur_req = "R9";
    ids[13] = 900; ids[14] = 3;
    add(bits({13}));
    eng_busy = 1; step();
    add(bits({14}));
    step();
    chk(sel_idx == 13, "R9", "offer held while busy", sel_idx, 13);
    tx_done = 1; step(); tx_done = 0; eng_busy = 0; step();
    chk(sel_valid && sel_idx == 14, "R9", "re-evaluated after done", sel_idx, 14);
    expect_order("R9", {14});

    // hold released by idle without completion
    ids[15] = 500; ids[16] = 2;
    add(bits({15}));
    eng_busy = 1; step();
    add(bits({16}));
    chk(sel_idx == 15, "R9", "held before idle", sel_idx, 15);
    eng_busy = 0; step();
    chk(sel_idx == 16 && pending[15], "R9", "re-evaluated on idle", sel_idx, 16);
    expect_order("R9", {16, 15});

    // interrupt mask
    cur_req = "R11";
    irq_cnt = 0;
    irq_mask = bits({17});
    add(bits({17, 18}));
    expect_order("R11", {17, 18});
    chk(irq_cnt == 1, "R11", "masked interrupt count", irq_cnt, 1);

    step();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule